// File: doc/BRIEF.md
# Microcode Next-Address Sequencer

This block picks the control-store address for the next cycle of a microcoded controller. It holds the current microstate in a register. Each cycle it forms the next microstate from three fields of the current microinstruction: a 6-bit suggested address, a 3-bit test selector and a dispatch flag. It also looks at a few status inputs: memory ready, branch enable, interrupt request, the 4-bit opcode and bit 11 of the instruction register.

With no test selected, the next state is the suggested address. A test code ORs one status bit into one fixed bit of the suggested address, so one microinstruction can reach two states that differ in that bit. The dispatch flag overrides all of this. It sends the sequencer to state 0 to 15, chosen by the opcode, which is how decode fans out to the per-instruction microcode. The control store and the datapath are outside this block. The microinstruction fields arrive as ports.

Top module: `useq_next_addr`

## Requirements
- R1: While `rst_ni` is low, `state_o` is 18, the fetch-start state.
- R2: When `dispatch_i` is 1, `next_state_o` is the opcode zero-extended to 6 bits (0..15), whatever `jump_addr_i`, `cond_sel_i` and the status inputs hold.
- R3: With `dispatch_i` 0 and `cond_sel_i` = 0, `next_state_o` equals `jump_addr_i`.
- R4: With `dispatch_i` 0 and `cond_sel_i` = 1 (memory ready test), `next_state_o` is `jump_addr_i` with `mem_ready_i` ORed into bit 1 (for example 33 becomes 35 when ready).
- R5: With `dispatch_i` 0 and `cond_sel_i` = 2 (branch test), `next_state_o` is `jump_addr_i` with `branch_en_i` ORed into bit 0.
- R6: With `dispatch_i` 0 and `cond_sel_i` = 3 (subroutine addressing mode test), `next_state_o` is `jump_addr_i` with `ir_bit11_i` ORed into bit 0.
- R7: With `dispatch_i` 0 and `cond_sel_i` = 5 (interrupt test), `next_state_o` is `jump_addr_i` with `irq_i` ORed into bit 4, so a suggested 33 gives 33 without a request and 49 with one.
- R8: Codes 4, 6 and 7 of `cond_sel_i` act as unconditional: `next_state_o` equals `jump_addr_i` and no status input changes it.
- R9: On every rising clock edge out of reset, `state_o` takes the value `next_state_o` had before the edge. When the suggested address equals the current state, the memory test is selected and `mem_ready_i` is 0, the state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| jump_addr_i | input | 6 | Suggested next address from the microinstruction |
| cond_sel_i | input | 3 | Test selector from the microinstruction |
| dispatch_i | input | 1 | Opcode dispatch flag from the microinstruction |
| mem_ready_i | input | 1 | Memory operation complete |
| branch_en_i | input | 1 | Branch taken |
| irq_i | input | 1 | Interrupt request |
| opcode_i | input | 4 | Instruction opcode |
| ir_bit11_i | input | 1 | Instruction bit 11, selects the addressing mode |
| state_o | output | 6 | Current microstate |
| next_state_o | output | 6 | Microstate for the next cycle |

## Verification
Random suggested addresses are mixed with all eight test codes, random status bits and occasional dispatch. Any status bit that lands in the wrong position, or is gated by the wrong code, shows up as a wrong address. Directed cases walk a fetch path:
- 18 with interrupt test to 33 or 49, then a memory wait that holds 33 while not ready and moves to 35 when ready.
- Dispatch with a deliberately conflicting suggested address and test code, which separates the override from the normal path.
- Branch and addressing tests with suggested addresses whose bit 0 is already set, so an OR cannot be mistaken for a replace.
- Reset asserted in the middle of the run.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [2:0] {
    COND_NONE = 3'd0,
    COND_MEM  = 3'd1,
    COND_BR   = 3'd2,
    COND_ADDR = 3'd3,
    COND_RSV4 = 3'd4,
    COND_IRQ  = 3'd5,
    COND_RSV6 = 3'd6,
    COND_RSV7 = 3'd7
  } cond_e;
endpackage

// File: rtl/useq_cond_unit.sv
module useq_cond_unit
  import useq_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int MEM_BIT = 1,
  parameter int BR_BIT  = 0,
  parameter int IRQ_BIT = 4
) (
  input  cond_e             cond_i,
  input  logic              mem_ready_i,
  input  logic              branch_en_i,
  input  logic              ir_bit11_i,
  input  logic              irq_i,
  output logic [ADDR_W-1:0] or_mask_o
);
  logic hit_mem, hit_br, hit_irq;

  always_comb begin
    hit_mem = (cond_i == COND_MEM) && mem_ready_i;
    hit_irq = (cond_i == COND_IRQ) && irq_i;
    hit_br  = ((cond_i == COND_BR) && branch_en_i) ||
              ((cond_i == COND_ADDR) && ir_bit11_i);
  end

  // one OR term per address bit; bit positions are parameters
  for (genvar b = 0; b < ADDR_W; b++) begin : g_mask
    assign or_mask_o[b] = ((MEM_BIT == b) && hit_mem) ||
                          ((BR_BIT  == b) && hit_br)  ||
                          ((IRQ_BIT == b) && hit_irq);
  end
endmodule

// File: rtl/useq_addr_select.sv
module useq_addr_select #(
  parameter int ADDR_W = 6,
  parameter int OPC_W  = 4
) (
  input  logic              dispatch_i,
  input  logic [ADDR_W-1:0] jump_addr_i,
  input  logic [ADDR_W-1:0] or_mask_i,
  input  logic [OPC_W-1:0]  opcode_i,
  output logic [ADDR_W-1:0] next_o
);
  localparam int PAD_W = ADDR_W - OPC_W;

  logic [ADDR_W-1:0] dispatch_addr;

  if (PAD_W > 0) begin : g_pad
    assign dispatch_addr = {{PAD_W{1'b0}}, opcode_i};
  end else begin : g_nopad
    assign dispatch_addr = opcode_i[ADDR_W-1:0];
  end

  always_comb begin
    if (dispatch_i) next_o = dispatch_addr;
    else            next_o = jump_addr_i | or_mask_i;
  end
endmodule

// File: rtl/useq_state_reg.sv
module useq_state_reg #(
  parameter int          ADDR_W      = 6,
  parameter logic [ADDR_W-1:0] RESET_STATE = 6'd18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] d_i,
  output logic [ADDR_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RESET_STATE;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int OPC_W       = 4,
  parameter int COND_W      = 3,
  parameter int RESET_STATE = 18,
  parameter int MEM_BIT     = 1,
  parameter int BR_BIT      = 0,
  parameter int IRQ_BIT     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] jump_addr_i,
  input  logic [COND_W-1:0] cond_sel_i,
  input  logic              dispatch_i,
  input  logic              mem_ready_i,
  input  logic              branch_en_i,
  input  logic              irq_i,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic              ir_bit11_i,
  output logic [ADDR_W-1:0] state_o,
  output logic [ADDR_W-1:0] next_state_o
);
  localparam logic [ADDR_W-1:0] RST_ST = ADDR_W'(RESET_STATE);

  cond_e             cond;
  logic [ADDR_W-1:0] or_mask;

  assign cond = cond_e'(cond_sel_i);

  useq_cond_unit #(
    .ADDR_W (ADDR_W),
    .MEM_BIT(MEM_BIT),
    .BR_BIT (BR_BIT),
    .IRQ_BIT(IRQ_BIT)
  ) u_cond (
    .cond_i     (cond),
    .mem_ready_i(mem_ready_i),
    .branch_en_i(branch_en_i),
    .ir_bit11_i (ir_bit11_i),
    .irq_i      (irq_i),
    .or_mask_o  (or_mask)
  );

  useq_addr_select #(
    .ADDR_W(ADDR_W),
    .OPC_W (OPC_W)
  ) u_sel (
    .dispatch_i (dispatch_i),
    .jump_addr_i(jump_addr_i),
    .or_mask_i  (or_mask),
    .opcode_i   (opcode_i),
    .next_o     (next_state_o)
  );

  useq_state_reg #(
    .ADDR_W     (ADDR_W),
    .RESET_STATE(RST_ST)
  ) u_state (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (next_state_o),
    .q_o   (state_o)
  );
endmodule

// File: rtl/useq_next_addr_chk.sv
module useq_next_addr_chk #(
  parameter int ADDR_W  = 6,
  parameter int OPC_W   = 4,
  parameter int COND_W  = 3,
  parameter int MEM_BIT = 1,
  parameter int BR_BIT  = 0,
  parameter int IRQ_BIT = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] jump_addr_i,
  input logic [COND_W-1:0] cond_sel_i,
  input logic              dispatch_i,
  input logic              mem_ready_i,
  input logic              branch_en_i,
  input logic              irq_i,
  input logic [OPC_W-1:0]  opcode_i,
  input logic              ir_bit11_i,
  input logic [ADDR_W-1:0] state_o,
  input logic [ADDR_W-1:0] next_state_o
);
  logic uncond;
  assign uncond = (cond_sel_i == 3'd0) || (cond_sel_i == 3'd4) ||
                  (cond_sel_i == 3'd6) || (cond_sel_i == 3'd7);

  AST_STATE_FOLLOWS_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> state_o == $past(next_state_o)); // R9

  AST_DISPATCH_OPCODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dispatch_i |-> next_state_o == ADDR_W'(opcode_i)); // R2

  AST_UNCOND_IS_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dispatch_i && uncond) |-> next_state_o == jump_addr_i); // R8

  AST_MEM_BIT_OR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dispatch_i && cond_sel_i == 3'd1) |->
      next_state_o[MEM_BIT] == (jump_addr_i[MEM_BIT] | mem_ready_i)); // R4

  AST_BRANCH_BIT_OR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dispatch_i && cond_sel_i == 3'd2) |->
      next_state_o[BR_BIT] == (jump_addr_i[BR_BIT] | branch_en_i)); // R5

  AST_ADDR_MODE_BIT_OR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dispatch_i && cond_sel_i == 3'd3) |->
      next_state_o[BR_BIT] == (jump_addr_i[BR_BIT] | ir_bit11_i)); // R6

  AST_IRQ_BIT_OR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dispatch_i && cond_sel_i == 3'd5) |->
      next_state_o[IRQ_BIT] == (jump_addr_i[IRQ_BIT] | irq_i)); // R7

  AST_ONLY_ADDS_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dispatch_i |-> (next_state_o & jump_addr_i) == jump_addr_i); // R3

  AST_MEM_WAIT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dispatch_i && cond_sel_i == 3'd1 && !mem_ready_i && jump_addr_i == state_o)
      |=> $stable(state_o)); // R9
endmodule

bind useq_next_addr useq_next_addr_chk #(
  .ADDR_W (ADDR_W),
  .OPC_W  (OPC_W),
  .COND_W (COND_W),
  .MEM_BIT(MEM_BIT),
  .BR_BIT (BR_BIT),
  .IRQ_BIT(IRQ_BIT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .jump_addr_i (jump_addr_i),
  .cond_sel_i  (cond_sel_i),
  .dispatch_i  (dispatch_i),
  .mem_ready_i (mem_ready_i),
  .branch_en_i (branch_en_i),
  .irq_i       (irq_i),
  .opcode_i    (opcode_i),
  .ir_bit11_i  (ir_bit11_i),
  .state_o     (state_o),
  .next_state_o(next_state_o)
);

// File: tb/useq_next_addr_tb.sv
module useq_next_addr_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND     = 3000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic [5:0] jump_addr_i = '0;
  logic [2:0] cond_sel_i = '0;
  logic       dispatch_i = 1'b0;
  logic       mem_ready_i = 1'b0;
  logic       branch_en_i = 1'b0;
  logic       irq_i = 1'b0;
  logic [3:0] opcode_i = '0;
  logic       ir_bit11_i = 1'b0;
  logic [5:0] state_o;
  logic [5:0] next_state_o;

  int n_checks = 0;
  int n_fails  = 0;
  logic       exp_valid = 1'b0;
  logic [5:0] exp_state = '0;
  string      exp_tag = "R9";

  useq_next_addr u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .jump_addr_i(jump_addr_i),
    .cond_sel_i(cond_sel_i), .dispatch_i(dispatch_i), .mem_ready_i(mem_ready_i),
    .branch_en_i(branch_en_i), .irq_i(irq_i), .opcode_i(opcode_i),
    .ir_bit11_i(ir_bit11_i), .state_o(state_o), .next_state_o(next_state_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [5:0] model_next(logic d, logic [5:0] j, logic [2:0] c,
      logic r, logic ben, logic irq, logic [3:0] opc, logic b11);
    logic [5:0] n;
    if (d) return {2'b00, opc};
    n = j;
    case (c)
      3'd1: n[1] = n[1] | r;
      3'd2: n[0] = n[0] | ben;
      3'd3: n[0] = n[0] | b11;
      3'd5: n[4] = n[4] | irq;
      default: ;
    endcase
    return n;
  endfunction

  function automatic string req_tag(logic d, logic [2:0] c);
    if (d) return "R2";
    case (c)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, logic [5:0] act, logic [5:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: confirm last edge, drive, check combinational next
  task automatic step(logic d, logic [5:0] j, logic [2:0] c, logic r,
      logic ben, logic irq, logic [3:0] opc, logic b11);
    logic [5:0] e;
    @(negedge clk_i);
    if (exp_valid) check(exp_tag, state_o, exp_state);
    dispatch_i = d; jump_addr_i = j; cond_sel_i = c; mem_ready_i = r;
    branch_en_i = ben; irq_i = irq; opcode_i = opc; ir_bit11_i = b11;
    #1;
    e = model_next(d, j, c, r, ben, irq, opc, b11);
    check(req_tag(d, c), next_state_o, e);
    exp_state = e;
    exp_tag   = "R9";
    exp_valid = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    exp_valid = 1'b0;
    #1;
    check("R1", state_o, 6'd18);
    @(negedge clk_i);
    check("R1", state_o, 6'd18);
    rst_ni = 1'b1;
    #1;
    check("R1", state_o, 6'd18);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5));
    #1 rst_ni = 1'b0;
    #2 check("R1", state_o, 6'd18);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    // fetch start, interrupt test: 18 -> 33 (no request)
    step(1'b0, 6'd33, 3'd5, 1'b1, 1'b1, 1'b0, 4'hf, 1'b1);  // R7
    // memory wait at 33: hold while not ready
    step(1'b0, 6'd33, 3'd1, 1'b0, 1'b1, 1'b1, 4'h0, 1'b1);  // R4
    step(1'b0, 6'd33, 3'd1, 1'b0, 1'b0, 1'b1, 4'h0, 1'b0);
    @(negedge clk_i);
    check("R9", state_o, 6'd33);
    exp_valid = 1'b0;
    // ready -> 35
    step(1'b0, 6'd33, 3'd1, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0);  // R4
    // dispatch overrides conflicting fields
    step(1'b1, 6'd63, 3'd5, 1'b1, 1'b1, 1'b1, 4'd1, 1'b1);  // R2
    step(1'b1, 6'd20, 3'd0, 1'b0, 1'b0, 1'b0, 4'd15, 1'b0); // R2
    // instruction done -> 18
    step(1'b0, 6'd18, 3'd0, 1'b1, 1'b1, 1'b1, 4'd7, 1'b1);  // R3
    // interrupt present -> 49
    step(1'b0, 6'd33, 3'd5, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0);  // R7
    // branch, bit 0 already set stays set
    step(1'b0, 6'd0, 3'd2, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0);   // R5
    step(1'b0, 6'd1, 3'd2, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0);   // R5
    step(1'b0, 6'd20, 3'd3, 1'b1, 1'b0, 1'b1, 4'd0, 1'b1);  // R6 -> 21
    step(1'b0, 6'd20, 3'd3, 1'b1, 1'b1, 1'b1, 4'd0, 1'b0);  // R6 -> 20
    // reserved codes ignore all status
    for (int c = 4; c < 8; c++) begin
      if (c != 5) step(1'b0, 6'd0, 3'(c), 1'b1, 1'b1, 1'b1, 4'd9, 1'b1); // R8
    end
    @(negedge clk_i);
    check("R9", state_o, exp_state);
    exp_valid = 1'b0;

    do_reset();

    for (int i = 0; i < N_RAND; i++) begin
      step(($urandom % 8) == 0, 6'($urandom), 3'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 4'($urandom), 1'($urandom));
      if (i == N_RAND / 2) do_reset();
    end
    @(negedge clk_i);
    check("R9", state_o, exp_state);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule